// File: doc/BRIEF.md
# Prescaled Timebase Counter with Event Capture

This block keeps a time base made of two counters. A prescale counter advances once per enabled clock until it reaches a programmable terminal value. On that cycle it returns to zero and a free-running counter advances by one. The free-running counter therefore counts periods of `pre_cmp + 1` enabled clocks. Software treats the free-running counter as the high part of the time stamp and the prescale counter as the low part.

A rising edge on one of two event inputs captures both counters at once. A select input picks which event input is used. Each event input has its own two-state edge tracker:

- `EV_IDLE` means the line was last sampled low.
  - The `T_RISE` transition leads to `EV_ACTIVE` when the line is sampled high. Only this transition emits a capture pulse.
- `EV_ACTIVE` means the line was last sampled high.
  - The `T_FALL` transition leads back to `EV_IDLE` when the line is sampled low.
  - The `T_STAY` transition is taken otherwise, in both states.

A read strobe with a 2-bit address returns either pair one half at a time. Software reads the high part first and the low part second. Reading the high part latches the matching low part into a shadow register, so the two halves always belong together.

Top module: `tbase_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, both counters, both capture registers, both shadow registers and `rd_data` are zero.
- R2: On each clock edge with `cnt_en` high, the prescale counter increments if it is below `pre_cmp`. If it is equal to or above `pre_cmp`, it becomes zero and the free-running counter increments on the same edge.
- R3: With `pre_cmp` equal to zero, the free-running counter increments on every enabled clock and the prescale counter stays at zero.
- R4: While `cnt_en` is low, both counters keep their values.
- R5: A read takes effect on the clock edge where `rd_en` is high, and the result appears on `rd_data` after that edge. Address 0 returns the free-running counter and copies the prescale counter into the live shadow register. Address 1 returns the live shadow register. When `rd_en` is low, `rd_data` keeps its value.
- R6: A capture pulse is produced when the selected event line is sampled high after being sampled low. `cap_sel` = 0 selects `cap_evt[0]` and `cap_sel` = 1 selects `cap_evt[1]`. The pulse stores the pre-edge prescale and free-running values into the capture registers.
- R7: A selected line held high for several cycles gives exactly one capture. Activity on the unselected line causes no capture.
- R8: Address 2 returns the captured free-running value and copies the captured prescale value into the capture shadow register. Address 3 returns the capture shadow register. A capture between these two reads does not change what address 3 returns.
- R9: A new capture overwrites the previous captured pair, whether or not that pair has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Counter run enable |
| pre_cmp | input | CNT_W | Prescale terminal value |
| cap_sel | input | SEL_W | Chooses the capture event source |
| cap_evt | input | SRC_N | Capture event lines |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address: 0 live high, 1 live low, 2 captured high, 3 captured low |
| rd_data | output | CNT_W | Registered read data |

## Verification
All internal state reaches the ports only through reads, so any fault shows up as a wrong `rd_data` value one cycle after the read strobe that exposes it. A miscounted prescale counter or a missed wrap appears on the next live-pair read and stays wrong from then on, because the error accumulates. A stuck edge tracker either loses captures or repeats them. This shows on the next read at address 2 or 3. A shadow that follows its source live rather than latching shows only when a count or a capture falls between the high-part read and the low-part read, so the stimulus places reads back to back and with gaps between them.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    // Read address map: the high part of each pair sits at the even address
    typedef enum logic [1:0] {
        RA_LIVE_HI = 2'd0,
        RA_LIVE_LO = 2'd1,
        RA_CAP_HI  = 2'd2,
        RA_CAP_LO  = 2'd3
    } rd_addr_e;

    // Edge tracker states for one event line
    typedef enum logic {
        EV_IDLE   = 1'b0,
        EV_ACTIVE = 1'b1
    } ev_state_e;

endpackage

// File: rtl/tbase_prescale.sv
module tbase_prescale #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] pre_cmp,
    output logic [CNT_W-1:0] uc_o,
    output logic [CNT_W-1:0] frc_o
);

    logic [CNT_W-1:0] uc_q;
    logic [CNT_W-1:0] frc_q;
    logic             at_term;

    // Treating "at or above" as terminal keeps a lowered compare value from
    // letting the prescaler run all the way around.
    assign at_term = (uc_q >= pre_cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uc_q  <= '0;
            frc_q <= '0;
        end else if (cnt_en) begin
            if (at_term) begin
                uc_q  <= '0;
                frc_q <= frc_q + CNT_W'(1);
            end else begin
                uc_q  <= uc_q + CNT_W'(1);
            end
        end
    end

    assign uc_o  = uc_q;
    assign frc_o = frc_q;

endmodule

// File: rtl/tbase_edge_fsm.sv
module tbase_edge_fsm
    import tbase_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    output logic rise_o
);

    ev_state_e state_q;
    ev_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EV_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: T_RISE, T_FALL, T_STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE:   if (evt_i)  state_d = EV_ACTIVE;
            EV_ACTIVE: if (!evt_i) state_d = EV_IDLE;
            default:   state_d = EV_IDLE;
        endcase
    end

    // Output: a pulse only on T_RISE
    always_comb begin
        rise_o = 1'b0;
        unique case (state_q)
            EV_IDLE:   rise_o = evt_i;
            EV_ACTIVE: rise_o = 1'b0;
            default:   rise_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tbase_capture.sv
module tbase_capture #(
    parameter int CNT_W = 32,
    parameter int SRC_N = 2,
    localparam int SEL_W = (SRC_N > 1) ? $clog2(SRC_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] cap_sel,
    input  logic [SRC_N-1:0] cap_evt,
    input  logic [CNT_W-1:0] uc_i,
    input  logic [CNT_W-1:0] frc_i,
    output logic             pulse_o,
    output logic [CNT_W-1:0] cap_uc_o,
    output logic [CNT_W-1:0] cap_frc_o
);

    logic [SRC_N-1:0] rise;
    logic [CNT_W-1:0] cap_uc_q;
    logic [CNT_W-1:0] cap_frc_q;

    // One tracker per source, so changing the selection cannot fake an edge
    // on a line that was already high.
    for (genvar s = 0; s < SRC_N; s++) begin : g_src
        tbase_edge_fsm u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (cap_evt[s]),
            .rise_o (rise[s])
        );
    end

    assign pulse_o = rise[cap_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_uc_q  <= '0;
            cap_frc_q <= '0;
        end else if (pulse_o) begin
            cap_uc_q  <= uc_i;
            cap_frc_q <= frc_i;
        end
    end

    assign cap_uc_o  = cap_uc_q;
    assign cap_frc_o = cap_frc_q;

endmodule

// File: rtl/tbase_readport.sv
module tbase_readport
    import tbase_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    input  logic [CNT_W-1:0] uc_i,
    input  logic [CNT_W-1:0] frc_i,
    input  logic [CNT_W-1:0] cap_uc_i,
    input  logic [CNT_W-1:0] cap_frc_i,
    output logic [CNT_W-1:0] rd_data
);

    logic [CNT_W-1:0] live_sh_q;
    logic [CNT_W-1:0] cap_sh_q;
    logic [CNT_W-1:0] rd_q;
    logic [CNT_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        unique case (rd_addr)
            RA_LIVE_HI: rd_mux = frc_i;
            RA_LIVE_LO: rd_mux = live_sh_q;
            RA_CAP_HI:  rd_mux = cap_frc_i;
            RA_CAP_LO:  rd_mux = cap_sh_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_sh_q <= '0;
            cap_sh_q  <= '0;
            rd_q      <= '0;
        end else if (rd_en) begin
            rd_q <= rd_mux;
            if (rd_addr == RA_LIVE_HI) live_sh_q <= uc_i;
            if (rd_addr == RA_CAP_HI)  cap_sh_q  <= cap_uc_i;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/tbase_timer.sv
module tbase_timer #(
    parameter int CNT_W = 32,
    parameter int SRC_N = 2,
    localparam int SEL_W = (SRC_N > 1) ? $clog2(SRC_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] pre_cmp,
    input  logic [SEL_W-1:0] cap_sel,
    input  logic [SRC_N-1:0] cap_evt,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data
);

    logic [CNT_W-1:0] uc;
    logic [CNT_W-1:0] frc;
    logic [CNT_W-1:0] cap_uc;
    logic [CNT_W-1:0] cap_frc;
    logic             cap_pulse;

    tbase_prescale #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .pre_cmp (pre_cmp),
        .uc_o    (uc),
        .frc_o   (frc)
    );

    tbase_capture #(.CNT_W(CNT_W), .SRC_N(SRC_N)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_sel   (cap_sel),
        .cap_evt   (cap_evt),
        .uc_i      (uc),
        .frc_i     (frc),
        .pulse_o   (cap_pulse),
        .cap_uc_o  (cap_uc),
        .cap_frc_o (cap_frc)
    );

    tbase_readport #(.CNT_W(CNT_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .uc_i      (uc),
        .frc_i     (frc),
        .cap_uc_i  (cap_uc),
        .cap_frc_i (cap_frc),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/tbase_timer_chk.sv
module tbase_timer_chk #(
    parameter int CNT_W = 32,
    parameter int SEL_W = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic [CNT_W-1:0] pre_cmp,
    input logic [SEL_W-1:0] cap_sel,
    input logic [CNT_W-1:0] uc,
    input logic [CNT_W-1:0] frc,
    input logic             cap_pulse,
    input logic [CNT_W-1:0] cap_uc,
    input logic [CNT_W-1:0] cap_frc,
    input logic             rd_en,
    input logic [1:0]       rd_addr,
    input logic [CNT_W-1:0] rd_data
);

    // R2
    uc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && uc < pre_cmp) |=> (uc == $past(uc) + CNT_W'(1)) && $stable(frc));

    // R2
    uc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && uc >= pre_cmp) |=> (uc == '0) && (frc == $past(frc) + CNT_W'(1)));

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(uc) && $stable(frc));

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R5
    rd_live_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == 2'd0) |=> rd_data == $past(frc));

    // R9
    cap_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> (cap_frc == $past(frc)) && (cap_uc == $past(uc)));

    // R7
    cap_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> (!cap_pulse || cap_sel != $past(cap_sel)));

    // R6
    cap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pulse |=> $stable(cap_frc) && $stable(cap_uc));

endmodule

bind tbase_timer tbase_timer_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .pre_cmp   (pre_cmp),
    .cap_sel   (cap_sel),
    .uc        (uc),
    .frc       (frc),
    .cap_pulse (cap_pulse),
    .cap_uc    (cap_uc),
    .cap_frc   (cap_frc),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
);

// File: tb/tbase_timer_tb.sv
`timescale 1ns/1ps
module tbase_timer_tb;

    localparam int CNT_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cnt_en = 1'b0;
    logic [CNT_W-1:0] pre_cmp = '0;
    logic [0:0]       cap_sel = 1'b0;
    logic [1:0]       cap_evt = 2'b00;
    logic             rd_en = 1'b0;
    logic [1:0]       rd_addr = 2'd0;
    logic [CNT_W-1:0] rd_data;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string tag = "R1";

    // Bench model, written from the requirements
    logic [CNT_W-1:0] m_uc = '0, m_frc = '0, m_cuc = '0, m_cfrc = '0;
    logic [CNT_W-1:0] m_lsh = '0, m_csh = '0, m_rd = '0;
    logic [1:0]       m_prev = 2'b00;

    always #10 clk = ~clk;

    tbase_timer u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .pre_cmp (pre_cmp),
        .cap_sel (cap_sel),
        .cap_evt (cap_evt),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    function automatic logic [CNT_W-1:0] read_value(input logic [1:0] a);
        case (a)
            2'd0:    return m_frc;
            2'd1:    return m_lsh;
            2'd2:    return m_cfrc;
            default: return m_csh;
        endcase
    endfunction

    task automatic check_rd();
        checks++;
        if (rd_data !== m_rd) begin
            errors++;
            $display("FAIL %s: rd_data=%0h expected %0h", tag, rd_data, m_rd);
        end
    endtask

    // One cycle: check at the negedge, drive, advance the model, wait
    task automatic cyc(input logic en, input logic [CNT_W-1:0] cmp, input logic sel,
                       input logic [1:0] evt, input logic rd, input logic [1:0] addr);
        logic pulse;
        check_rd();
        cnt_en = en; pre_cmp = cmp; cap_sel = sel; cap_evt = evt;
        rd_en = rd; rd_addr = addr;
        pulse = evt[sel] && !m_prev[sel];
        if (rd) begin
            m_rd = read_value(addr);
            if (addr == 2'd0) m_lsh = m_uc;
            if (addr == 2'd2) m_csh = m_cuc;
        end
        if (pulse) begin
            m_cuc = m_uc;
            m_cfrc = m_frc;
        end
        if (en) begin
            if (m_uc >= cmp) begin
                m_uc = '0;
                m_frc = m_frc + 1;
            end else begin
                m_uc = m_uc + 1;
            end
        end
        m_prev = evt;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not end, actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5eed_1234);
        repeat (2) @(negedge clk);
        tag = "R1";
        check_rd();
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 4; a++) cyc(1'b0, 32'd3, 1'b0, 2'b00, 1'b1, 2'(a));

        tag = "R2";
        for (int i = 0; i < 9; i++) cyc(1'b1, 32'd2, 1'b0, 2'b00, 1'b0, 2'd0);
        cyc(1'b1, 32'd2, 1'b0, 2'b00, 1'b1, 2'd0);
        cyc(1'b1, 32'd2, 1'b0, 2'b00, 1'b1, 2'd1);

        tag = "R3";
        for (int i = 0; i < 5; i++) cyc(1'b1, 32'd0, 1'b0, 2'b00, 1'b1, 2'(i % 2));

        tag = "R4";
        cyc(1'b0, 32'd5, 1'b0, 2'b00, 1'b1, 2'd0);
        for (int i = 0; i < 4; i++) cyc(1'b0, 32'd5, 1'b0, 2'b00, 1'b0, 2'd0);
        cyc(1'b0, 32'd5, 1'b0, 2'b00, 1'b1, 2'd0);
        cyc(1'b0, 32'd5, 1'b0, 2'b00, 1'b1, 2'd1);

        tag = "R7";
        for (int i = 0; i < 6; i++) cyc(1'b1, 32'd1, 1'b0, 2'b01, 1'b1, 2'd2);
        for (int i = 0; i < 4; i++) cyc(1'b1, 32'd1, 1'b0, 2'(i[0] ? 2'b10 : 2'b00), 1'b0, 2'd0);
        cyc(1'b1, 32'd1, 1'b0, 2'b00, 1'b1, 2'd2);
        cyc(1'b1, 32'd1, 1'b0, 2'b00, 1'b1, 2'd3);

        tag = "R8";
        cyc(1'b1, 32'd4, 1'b1, 2'b10, 1'b0, 2'd0);
        cyc(1'b1, 32'd4, 1'b1, 2'b00, 1'b1, 2'd2);
        cyc(1'b1, 32'd4, 1'b1, 2'b10, 1'b0, 2'd0);
        cyc(1'b1, 32'd4, 1'b1, 2'b00, 1'b1, 2'd3);

        tag = "R9";
        cyc(1'b1, 32'd4, 1'b1, 2'b10, 1'b0, 2'd0);
        cyc(1'b1, 32'd4, 1'b1, 2'b00, 1'b0, 2'd0);
        cyc(1'b1, 32'd4, 1'b1, 2'b10, 1'b0, 2'd0);
        cyc(1'b1, 32'd4, 1'b1, 2'b00, 1'b1, 2'd2);
        cyc(1'b1, 32'd4, 1'b1, 2'b00, 1'b1, 2'd3);

        tag = "R2 R5 R6";
        for (int i = 0; i < 4000; i++) begin
            logic [CNT_W-1:0] cmp;
            cmp = (i % 500 < 100) ? 32'd0 : 32'($urandom_range(6));
            cyc(($urandom_range(9) != 0), cmp, ((i / 300) % 2 == 1),
                2'($urandom_range(3)), ($urandom_range(2) != 0), 2'($urandom_range(3)));
        end
        check_rd();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule